// File: doc/BRIEF.md
# UART Transmit Buffer with Interrupt and DMA Request Control

This block is the transmit half of a 16550-class serial channel, without the serializer itself. Host writes to the transmit holding register arrive on a valid/ready write stream and go into a 16-character buffer. In non-buffered mode the same storage behaves as a single holding register. The head character moves into a one-character transmit shift register model. That register offers the character to the serializer and releases it when the serializer reports completion.

From the buffer level the block derives four things: the two line-status empty flags, a transmit-empty interrupt with its identification bit, and a DMA request line (TXRDY). The interrupt is re-armed only after a set number of host writes. TXRDY has two behaviours. In single-transfer mode it requests one character at a time. In burst mode it uses a programmable empty-space threshold with hysteresis: it asserts when the free space exceeds the threshold and holds until the buffer is full.

Back-pressure rules: a write transfers on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the buffer is at capacity or a flush is requested, and a write offered while `wr_ready` is low is dropped. The serializer side is a hold-until-done channel. `sh_valid` stays high with stable `sh_data` until the cycle in which `sh_done` is sampled high.

Top module: `uart_txq_ctrl`

## Requirements
- R1: With `fifo_en`=1 the buffer holds up to 16 characters and delivers them on `sh_data` in write order. `wr_ready` is 0 when 16 are held, and a write offered then is dropped.
- R2: With `fifo_en`=0 the capacity is one character, so `wr_ready` falls after a single accepted write until that character leaves for the shift register.
- R3: The shift register loads the head character on the edge after the first cycle in which it is empty and the buffer is not. A loaded character is released on the edge where `sh_done`=1, so the next load comes one cycle after completion. `sh_done` has no effect while `sh_valid`=0.
- R4: `lsr_thr_empty` is 1 exactly when the buffer holds no character. `lsr_tx_empty` is 1 exactly when the buffer and the shift register are both empty.
- R5: While `tx_irq_en`=1 and the interrupt is armed, an empty buffer sets the pending transmit interrupt on the next edge. `tx_irq` and `irq_id_thre` (identification bit 1) both show it, and both are always 0 while `tx_irq_en`=0.
- R6: An accepted write or an `irq_id_rd` pulse clears the pending interrupt on the next edge. Clearing `tx_irq_en` also discards it.
- R7: Once an interrupt has fired, the interrupt is not armed again until two accepted writes with `fifo_en`=1 (one with `fifo_en`=0). The armed state is 1 after reset.
- R8: In single-transfer mode (`burst_mode`=0 or `fifo_en`=0), `dma_txrdy` equals buffer-empty.
- R9: In burst mode (`fifo_en`=1, `burst_mode`=1), `dma_txrdy` is 1 whenever free space exceeds a limit chosen by `thresh_sel`: 0 gives 8, 1 gives 4, 2 gives 2, 3 gives 0.
- R10: In burst mode `dma_txrdy` is 0 when the buffer is full. When free space is between full and the limit, it keeps the value of the previous cycle.
- R11: A `flush` pulse empties the buffer and the shift register on the next edge, so both empty flags read 1. The write offered in that cycle is refused.
- R12: After reset the buffer and shift register are empty, no interrupt is pending, and `dma_txrdy`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = 16-character buffer, 0 = single holding register |
| burst_mode | input | 1 | DMA style: 1 = burst, 0 = single transfer |
| thresh_sel | input | 2 | Burst-mode free-space limit select |
| flush | input | 1 | Empties buffer and shift register |
| tx_irq_en | input | 1 | Transmit-empty interrupt enable |
| irq_id_rd | input | 1 | Pulse: host read of interrupt identification |
| wr_valid | input | 1 | Holding-register write offered |
| wr_data | input | 8 | Character written |
| wr_ready | output | 1 | Buffer can take a write this cycle |
| sh_valid | output | 1 | Shift register holds a character |
| sh_data | output | 8 | Character in the shift register |
| sh_done | input | 1 | Serializer finished the current character |
| tx_irq | output | 1 | Transmit-empty interrupt request |
| irq_id_thre | output | 1 | Interrupt identification bit 1 (transmit source) |
| lsr_thr_empty | output | 1 | Line status bit 5: holding buffer empty |
| lsr_tx_empty | output | 1 | Line status bit 6: buffer and shift register empty |
| dma_txrdy | output | 1 | DMA transmit request |

## Verification
The hardest state to reach is the burst-mode band where free space lies between zero and the limit. There `dma_txrdy` depends on the path taken, not on the level: a buffer filled to full and drained into the band must read 0, and one filled from below into the band must read 1. Interrupt re-arming after exactly one write in buffered mode is similarly path-dependent. The stimulus runs phases with fixed write and completion rates, some writing on every cycle with the serializer stalled, then draining slowly. Every phase starts with a flush and new random mode settings. A reference model in the bench tracks each step.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

  typedef enum logic {
    REQ_SINGLE = 1'b0,
    REQ_BURST  = 1'b1
  } req_style_e;

  // Free-space limit selected by the 2-bit burst threshold field.
  function automatic int unsigned space_floor(input logic [1:0] sel,
                                              input int unsigned depth);
    int unsigned lim;
    unique case (sel)
      2'd0:    lim = depth / 2;
      2'd1:    lim = depth / 4;
      2'd2:    lim = depth / 8;
      default: lim = 0;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head = mem[rp];

endmodule

// File: rtl/txq_dma_ready.sv
module txq_dma_ready
  import uart_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  req_style_e    style,
  input  logic [1:0]    sel,
  input  logic [CW-1:0] count,
  output logic          txrdy
);

  logic          hold_q;
  logic [CW-1:0] space;
  logic [CW-1:0] limit;

  assign space = CW'(DEPTH) - count;
  assign limit = CW'(space_floor(sel, DEPTH));

  always_comb begin
    if (style == REQ_SINGLE)      txrdy = (count == '0);
    else if (space > limit)       txrdy = 1'b1;
    else if (count == CW'(DEPTH)) txrdy = 1'b0;
    else                          txrdy = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b1;
    else        hold_q <= txrdy;
  end

endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
  parameter int unsigned REARM_BUF  = 2,
  parameter int unsigned REARM_HOLD = 1,
  localparam int unsigned NW = $clog2(REARM_BUF + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic buffered,
  input  logic empty,
  input  logic wr_acc,
  input  logic id_rd,
  output logic pending
);

  logic          armed;
  logic [NW-1:0] wcnt;
  logic [NW-1:0] need;
  logic          fire;

  assign need = buffered ? NW'(REARM_BUF) : NW'(REARM_HOLD);
  assign fire = armed && enable && empty && !wr_acc && !id_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      armed   <= 1'b1;
      wcnt    <= '0;
    end else begin
      if (!enable)               pending <= 1'b0;
      else if (fire)             pending <= 1'b1;
      else if (wr_acc || id_rd)  pending <= 1'b0;

      if (fire) begin
        armed <= 1'b0;
        wcnt  <= '0;
      end else if (!armed && wr_acc) begin
        wcnt <= wcnt + NW'(1);
        if (wcnt + NW'(1) >= need) armed <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_txq_ctrl.sv
module uart_txq_ctrl
  import uart_txq_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fifo_en,
  input  logic         burst_mode,
  input  logic [1:0]   thresh_sel,
  input  logic         flush,
  input  logic         tx_irq_en,
  input  logic         irq_id_rd,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  output logic         sh_valid,
  output logic [W-1:0] sh_data,
  input  logic         sh_done,
  output logic         tx_irq,
  output logic         irq_id_thre,
  output logic         lsr_thr_empty,
  output logic         lsr_tx_empty,
  output logic         dma_txrdy
);

  logic [CW-1:0] count;
  logic [CW-1:0] cap;
  logic [W-1:0]  head;
  logic          wr_acc;
  logic          load;
  logic          tsr_full;
  logic [W-1:0]  tsr_q;
  logic          pending;
  req_style_e    style;

  assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
  assign wr_ready = !flush && (count < cap);
  assign wr_acc   = wr_valid && wr_ready;
  assign load     = !tsr_full && (count != '0) && !flush;
  assign style    = (fifo_en && burst_mode) ? REQ_BURST : REQ_SINGLE;

  txq_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (wr_acc),
    .din   (wr_data),
    .pop   (load),
    .head  (head),
    .count (count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsr_full <= 1'b0;
      tsr_q    <= '0;
    end else if (flush) begin
      tsr_full <= 1'b0;
    end else if (load) begin
      tsr_full <= 1'b1;
      tsr_q    <= head;
    end else if (sh_done && tsr_full) begin
      tsr_full <= 1'b0;
    end
  end

  txq_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (tx_irq_en),
    .buffered (fifo_en),
    .empty    (count == '0),
    .wr_acc   (wr_acc),
    .id_rd    (irq_id_rd),
    .pending  (pending)
  );

  txq_dma_ready #(.DEPTH(DEPTH)) u_dma (
    .clk   (clk),
    .rst_n (rst_n),
    .style (style),
    .sel   (thresh_sel),
    .count (count),
    .txrdy (dma_txrdy)
  );

  assign sh_valid      = tsr_full;
  assign sh_data       = tsr_q;
  assign tx_irq        = pending && tx_irq_en;
  assign irq_id_thre   = pending && tx_irq_en;
  assign lsr_thr_empty = (count == '0);
  assign lsr_tx_empty  = (count == '0) && !tsr_full;

endmodule

// File: rtl/txq_checker.sv
module txq_checker (
  input logic clk,
  input logic rst_n,
  input logic fifo_en,
  input logic burst_mode,
  input logic flush,
  input logic tx_irq_en,
  input logic irq_id_rd,
  input logic wr_valid,
  input logic wr_ready,
  input logic sh_valid,
  input logic sh_done,
  input logic tx_irq,
  input logic lsr_thr_empty,
  input logic lsr_tx_empty,
  input logic dma_txrdy
);

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && sh_done && !flush) |=> !sh_valid);

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sh_valid && !lsr_thr_empty && !flush) |=> sh_valid);

  assert_flags_nest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_tx_empty |-> lsr_thr_empty);

  assert_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_irq_en |-> !tx_irq);

  assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && wr_valid && wr_ready) |=> !tx_irq);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && irq_id_rd) |=> !tx_irq);

  assert_full_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && burst_mode && !flush && !wr_ready) |-> !dma_txrdy);

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> lsr_tx_empty);

endmodule

bind uart_txq_ctrl txq_checker u_txq_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .fifo_en       (fifo_en),
  .burst_mode    (burst_mode),
  .flush         (flush),
  .tx_irq_en     (tx_irq_en),
  .irq_id_rd     (irq_id_rd),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .sh_valid      (sh_valid),
  .sh_done       (sh_done),
  .tx_irq        (tx_irq),
  .lsr_thr_empty (lsr_thr_empty),
  .lsr_tx_empty  (lsr_tx_empty),
  .dma_txrdy     (dma_txrdy)
);

// File: tb/uart_txq_ctrl_test.sv
`timescale 1ns/1ps
module uart_txq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1, burst_mode = 1'b0, flush = 1'b0;
  logic [1:0] thresh_sel = 2'd0;
  logic       tx_irq_en = 1'b0, irq_id_rd = 1'b0, wr_valid = 1'b0, sh_done = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready, sh_valid, tx_irq, irq_id_thre, lsr_thr_empty, lsr_tx_empty, dma_txrdy;
  logic [7:0] sh_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference model state
  logic [7:0] mq[$];
  bit         m_tsr_full = 0;
  logic [7:0] m_tsr = 8'h00;
  bit         m_pend = 0, m_armed = 1, m_hold = 1;
  int         m_wcnt = 0;

  always #4 clk = ~clk;

  uart_txq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .burst_mode(burst_mode),
    .thresh_sel(thresh_sel), .flush(flush), .tx_irq_en(tx_irq_en),
    .irq_id_rd(irq_id_rd), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .sh_valid(sh_valid), .sh_data(sh_data),
    .sh_done(sh_done), .tx_irq(tx_irq), .irq_id_thre(irq_id_thre),
    .lsr_thr_empty(lsr_thr_empty), .lsr_tx_empty(lsr_tx_empty),
    .dma_txrdy(dma_txrdy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lim_of(input logic [1:0] s);
    case (s)
      2'd0: return 8;
      2'd1: return 4;
      2'd2: return 2;
      default: return 0;
    endcase
  endfunction

  // R8 R9 R10 expected request line
  function automatic bit exp_txrdy(input bit fe, input bit bm, input logic [1:0] s,
                                   input int cnt, input bit hold);
    if (!(fe && bm)) return cnt == 0;
    if (16 - cnt > lim_of(s)) return 1'b1;
    if (cnt == 16) return 1'b0;
    return hold;
  endfunction

  function automatic bit exp_ready();
    int cap = fifo_en ? 16 : 1;
    return !flush && (mq.size() < cap);
  endfunction

  task automatic compare_all();
    int  cnt = mq.size();
    bit  e_int = m_pend && tx_irq_en;
    bit  e_rdy = exp_ready();
    bit  e_dma = exp_txrdy(fifo_en, burst_mode, thresh_sel, cnt, m_hold);
    check(wr_ready == e_rdy, fifo_en ? "R1 wr_ready" : "R2 wr_ready", wr_ready, e_rdy);
    check(sh_valid == m_tsr_full, "R3 sh_valid", sh_valid, m_tsr_full);
    if (m_tsr_full) check(sh_data == m_tsr, "R1 sh_data order", sh_data, m_tsr);
    check(lsr_thr_empty == (cnt == 0), "R4 lsr_thr_empty", lsr_thr_empty, cnt == 0);
    check(lsr_tx_empty == (cnt == 0 && !m_tsr_full), "R4 lsr_tx_empty",
          lsr_tx_empty, cnt == 0 && !m_tsr_full);
    check(tx_irq == e_int, "R5 R6 R7 tx_irq", tx_irq, e_int);
    check(irq_id_thre == e_int, "R5 irq_id_thre", irq_id_thre, e_int);
    check(dma_txrdy == e_dma,
          (fifo_en && burst_mode) ? "R9 R10 dma_txrdy" : "R8 dma_txrdy", dma_txrdy, e_dma);
  endtask

  // advance the model by one edge, using the inputs now driven
  task automatic model_step();
    bit acc  = wr_valid && exp_ready();
    bit ld   = !m_tsr_full && mq.size() > 0 && !flush;
    bit emp  = mq.size() == 0;
    bit fire = m_armed && tx_irq_en && emp && !acc && !irq_id_rd;
    int need = fifo_en ? 2 : 1;
    m_hold = exp_txrdy(fifo_en, burst_mode, thresh_sel, mq.size(), m_hold);
    if (!tx_irq_en)          m_pend = 0;
    else if (fire)           m_pend = 1;
    else if (acc || irq_id_rd) m_pend = 0;
    if (fire) begin
      m_armed = 0; m_wcnt = 0;
    end else if (!m_armed && acc) begin
      m_wcnt++;
      if (m_wcnt >= need) m_armed = 1;
    end
    if (flush) begin
      m_tsr_full = 0;
      mq.delete();
    end else begin
      if (ld) begin
        m_tsr = mq.pop_front();
        m_tsr_full = 1;
      end else if (sh_done && m_tsr_full) begin
        m_tsr_full = 0;
      end
      if (acc) mq.push_back(wr_data);
    end
  endtask

  // one cycle: check outputs, drive new inputs, advance model
  task automatic cycle(input bit wv, input bit dn, input bit rd, input bit fl);
    @(negedge clk);
    compare_all();
    wr_valid  = wv;
    wr_data   = 8'($urandom);
    sh_done   = dn;
    irq_id_rd = rd;
    flush     = fl;
    model_step();
  endtask

  task automatic run_phase(input bit fe, input bit bm, input logic [1:0] s, input bit ie,
                           input int pw, input int pd, input int pr, input int n);
    @(negedge clk);
    compare_all();
    fifo_en = fe; burst_mode = bm; thresh_sel = s; tx_irq_en = ie;
    wr_valid = 0; sh_done = 0; irq_id_rd = 0; flush = 1;   // R11 flush at phase start
    model_step();
    for (int i = 0; i < n; i++)
      cycle(($urandom % 100) < pw, ($urandom % 100) < pd, ($urandom % 100) < pr, 1'b0);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17C3E1));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    check(lsr_tx_empty == 1 && lsr_thr_empty == 1, "R12 empty after reset", lsr_tx_empty, 1);
    check(sh_valid == 0 && tx_irq == 0, "R12 idle after reset", sh_valid, 0);
    check(dma_txrdy == 1, "R12 dma_txrdy after reset", dma_txrdy, 1);
    check(wr_ready == 1, "R12 wr_ready after reset", wr_ready, 1);
    model_step();

    // directed: burst fill with stalled serializer, overflow writes, slow drain (R1 R9 R10)
    run_phase(1, 1, 2'd0, 1, 100, 0, 0, 40);
    run_phase(1, 1, 2'd0, 1, 0, 30, 0, 120);
    run_phase(1, 1, 2'd2, 0, 100, 0, 0, 30);
    run_phase(1, 1, 2'd2, 0, 10, 25, 0, 200);
    run_phase(1, 1, 2'd3, 0, 100, 0, 0, 30);
    run_phase(1, 1, 2'd1, 0, 60, 50, 0, 300);
    // directed: interrupt hysteresis (R5 R6 R7)
    run_phase(1, 0, 2'd0, 1, 15, 60, 10, 400);
    run_phase(0, 0, 2'd0, 1, 30, 50, 10, 400);
    run_phase(0, 1, 2'd1, 1, 70, 40, 5, 300);   // R2 R8 burst ignored without buffer

    // random phases
    for (int p = 0; p < 40; p++)
      run_phase($urandom % 4 != 0, $urandom % 2, 2'($urandom), $urandom % 3 != 0,
                $urandom % 101, $urandom % 101, $urandom % 20, 200 + $urandom % 200);

    // R11: flush mid-traffic with full buffer
    run_phase(1, 1, 2'd0, 1, 100, 0, 0, 25);
    cycle(1'b1, 1'b0, 1'b0, 1'b1);
    cycle(1'b0, 1'b0, 1'b0, 1'b0);
    check(lsr_tx_empty == 1, "R11 flush empties", lsr_tx_empty, 1);
    cycle(1'b0, 1'b0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule